// File: doc/BRIEF.md
# Single-Channel Memory Copy Engine

This block is one bus-mastering copy channel. Software programs a source address, a destination address and a 32-bit control word. Once started, the channel reads one unit from the source and writes it to the destination, one unit at a time, over a port with a request/ready handshake. A unit is 16 or 32 bits wide. After each unit both working addresses step forward, step back or stay fixed, as the control word selects.

A transfer starts in one of two ways. It can start at once when the enable bit is written from 0 to 1. It can also wait for the external trigger line that belongs to the selected start mode. One mode feeds a FIFO: each trigger moves a bounded burst, and the count still owed is written back into the control word. The channel holds a CPU-halt request for as long as it is busy.

Each unit is charged a cycle cost, which is the sum of the wait-state values of the source and destination address regions. Two extra cycles follow the last unit of a finished transfer. On completion the channel can raise a one-cycle interrupt, and it either clears its enable bit or stays armed for repeat use.

Top module: `dma_channel`

## Requirements
- R1: The working source and destination addresses are copied from the programmed address registers only when a control write changes bit 31 (enable) from 0 to 1. Writing an address register later does not move an address that is already loaded.
- R2: Control bits 22:21 select the destination step. 00 steps up, 01 steps down, 10 keeps the address fixed, and 11 steps up and also reloads the working destination from its programmed register at every start.
- R3: Control bits 24:23 select the source step. 00 steps up, 01 steps down and 10 keeps the address fixed. The unused code 11 behaves as step up.
- R4: Control bit 26 chooses the unit size. With 0, units are 16 bits and addresses move by 2; with 1, units are 32 bits and addresses move by 4. Every unit read is written unchanged to the destination.
- R5: The unit count sits in control bits 20:0. A count of 0 means 2^21 units.
- R6: Start mode is control bits 29:27. Mode 0 starts on the enable edge. Any other mode m waits, with enable set and the channel idle, for trig_in[m] to be high; other trigger lines have no effect.
- R7: In mode 7, one start moves at most 112 units. If units remain, the remaining count is written into bits 20:0, the channel returns to idle with enable still set, halt drops, and no interrupt or tail cycles occur.
- R8: A trigger that arrives while the channel is busy is ignored and does not add units.
- R9: When the full count is done, bit 31 is cleared unless bit 25 (repeat) is set. If bit 30 is set, irq is high for exactly one cycle.
- R10: After each unit's write is accepted, the channel waits cost cycles before the next step. Cost is the source region value plus the destination region value, where the region is address bits 27:24. For 16-bit units, regions 8 and 9 cost 6, region A costs 10, and every other region costs 1. For 32-bit units, regions 8 and 9 cost 12, region A costs 10, regions 2, 5 and 6 cost 2, and every other region costs 1.
- R11: cpu_halt is high in every cycle from the start until the channel is idle again. With a ready memory, a complete transfer of N units keeps it high for N*(2+cost)+2 cycles.
- R12: A read request holds its valid and address stable until ready is seen, and the same holds for a write request. A read and a write are never requested together. A stalled read lengthens the transfer by the stall cycles.
- R13: After reset the control word reads 0, the channel is idle, no request is raised and cpu_halt and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control |
| reg_wdata | input | 32 | Register write data |
| trig_in | input | 8 | Start triggers, one per start mode (bit 0 unused) |
| ctrl_word | output | 32 | Current control word, including written-back count and enable |
| mem_wide | output | 1 | Unit size of the current request (1 = 32 bit) |
| mem_rd_valid | output | 1 | Read request |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_ready | input | 1 | Read accepted, data valid |
| mem_rd_data | input | 32 | Read data |
| mem_wr_valid | output | 1 | Write request |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ready | input | 1 | Write accepted |
| cpu_halt | output | 1 | Halt request while the channel is busy |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench measures how long cpu_halt stays high and compares it with N*(2+cost)+2. A wrong region table, a missing tail or an off-by-one in the wait counter therefore shows up as a wrong cycle total. It drives a repeating triggered transfer twice and checks that the source continues from where it stopped while the reloading destination starts again. A design that reloads on every start, or never reloads, writes the wrong addresses. The FIFO-feed cases check the burst limit of 112 units, the written-back remainder, and the treatment of count 0 as 2^21: a design that gets the zero count wrong leaves a remainder other than 0x1FFF90. The bench also checks stray triggers, a read stall and the invalid source step code, where a decoder that treats 11 as fixed repeats the first source address.

// File: rtl/dma_ch_pkg.sv
// Shared types and the region wait-state table for the copy channel.
// Assumes the region index is a 4-bit nibble taken from the address.
package dma_ch_pkg;

    localparam int COST_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_READ, ST_WRITE, ST_WAIT, ST_TAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        STEP_UP = 2'd0, STEP_DOWN = 2'd1, STEP_HOLD = 2'd2, STEP_UP_RELOAD = 2'd3
    } step_mode_t;

    typedef struct packed {
        logic       enable;
        logic       irq_en;
        logic [2:0] start_mode;
        logic       wide;
        logic       repeat_en;
        step_mode_t src_step;
        step_mode_t dst_step;
    } ctrl_fields_t;

    // Wait-state value of one region for the given unit width
    function automatic logic [COST_W-1:0] region_cost(input logic wide, input logic [3:0] region);
        case (region)
            4'h8, 4'h9:       return wide ? COST_W'(12) : COST_W'(6);
            4'hA:             return COST_W'(10);
            4'h2, 4'h5, 4'h6: return wide ? COST_W'(2) : COST_W'(1);
            default:          return COST_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/dma_ch_decode.sv
// Splits the control word into its fields and turns the count field into
// an effective unit count, where 0 stands for the largest count plus one.
// Assumes CNT_W <= 21 so the count does not overlap the mode bits.
module dma_ch_decode #(
    parameter int CNT_W = 21
) (
    input  logic [31:0]                ctrl,
    output dma_ch_pkg::ctrl_fields_t   fields,
    output logic [CNT_W:0]             count_eff
);
    import dma_ch_pkg::*;

    // Field extraction and the zero-count rule
    always_comb begin
        fields.enable     = ctrl[31];
        fields.irq_en     = ctrl[30];
        fields.start_mode = ctrl[29:27];
        fields.wide       = ctrl[26];
        fields.repeat_en  = ctrl[25];
        fields.src_step   = step_mode_t'(ctrl[24:23]);
        fields.dst_step   = step_mode_t'(ctrl[22:21]);
        if (ctrl[CNT_W-1:0] == '0)
            count_eff = {1'b1, {CNT_W{1'b0}}};
        else
            count_eff = {1'b0, ctrl[CNT_W-1:0]};
    end
endmodule

// File: rtl/dma_ch_step.sv
// Computes the next working address after one unit.
// Assumes the step is 2 for 16-bit units and 4 for 32-bit units.
module dma_ch_step #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]      addr,
    input  dma_ch_pkg::step_mode_t mode,
    input  logic                   wide,
    output logic [ADDR_W-1:0]      next_addr
);
    import dma_ch_pkg::*;

    logic [ADDR_W-1:0] stride;

    // Pick the stride and apply the step direction
    always_comb begin
        stride = wide ? ADDR_W'(4) : ADDR_W'(2);
        case (mode)
            STEP_DOWN: next_addr = addr - stride;
            STEP_HOLD: next_addr = addr;
            default:   next_addr = addr + stride;
        endcase
    end
endmodule

// File: rtl/dma_ch_cost.sv
// Cycle cost of one unit: the source region value plus the destination
// region value, from the table that matches the unit width.
module dma_ch_cost (
    input  logic                          wide,
    input  logic [3:0]                    src_region,
    input  logic [3:0]                    dst_region,
    output logic [dma_ch_pkg::COST_W-1:0] cost
);
    import dma_ch_pkg::*;

    // Sum of the two table lookups
    always_comb cost = region_cost(wide, src_region) + region_cost(wide, dst_region);
endmodule

// File: rtl/dma_channel.sv
// Single memory copy channel: register file, start logic, unit sequencer,
// request/ready memory port, halt request and completion interrupt.
// Assumes software writes registers only while the channel is idle, and
// that the address is at least 28 bits wide (region = bits 27:24).
module dma_channel #(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 21,
    parameter int FIFO_CHUNK  = 112,
    parameter int TAIL_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic [7:0]        trig_in,
    output logic [31:0]       ctrl_word,
    output logic              mem_wide,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    input  logic              mem_wr_ready,
    output logic              cpu_halt,
    output logic              irq
);
    import dma_ch_pkg::*;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam int         REM_W    = CNT_W + 1;
    localparam logic [2:0] MODE_FIFO = 3'd7;

    seq_state_t        state;
    logic [31:0]       ctrl_q, ctrl_next;
    logic [ADDR_W-1:0] src_reg, dst_reg, cur_src, cur_dst, src_nx, dst_nx;
    logic [REM_W-1:0]  rem_cnt, iter_cnt, count_eff;
    logic [COST_W-1:0] wait_cnt, unit_cost;
    logic [31:0]       data_q;
    ctrl_fields_t      fld;
    logic              ctrl_wr, en_rise, trig_hit, start_go;

    dma_ch_decode #(.CNT_W(CNT_W)) u_decode (
        .ctrl(ctrl_next), .fields(fld), .count_eff(count_eff)
    );
    dma_ch_step #(.ADDR_W(ADDR_W)) u_src_step (
        .addr(cur_src), .mode(fld.src_step), .wide(fld.wide), .next_addr(src_nx)
    );
    dma_ch_step #(.ADDR_W(ADDR_W)) u_dst_step (
        .addr(cur_dst), .mode(fld.dst_step), .wide(fld.wide), .next_addr(dst_nx)
    );
    dma_ch_cost u_cost (
        .wide(fld.wide), .src_region(cur_src[27:24]), .dst_region(cur_dst[27:24]),
        .cost(unit_cost)
    );

    // Start conditions: enable edge in mode 0, or the matching trigger when armed
    always_comb begin
        ctrl_wr   = reg_wr_en && (reg_sel == SEL_CTRL);
        ctrl_next = ctrl_wr ? reg_wdata : ctrl_q;
        en_rise   = ctrl_wr && !ctrl_q[31] && reg_wdata[31];
        trig_hit  = !ctrl_wr && fld.enable && (fld.start_mode != 3'd0)
                    && trig_in[fld.start_mode];
        start_go  = (state == ST_IDLE)
                    && ((en_rise && (fld.start_mode == 3'd0)) || trig_hit);
    end

    // Registers, working addresses and the unit sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ctrl_q   <= '0;
            src_reg  <= '0;
            dst_reg  <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            rem_cnt  <= '0;
            iter_cnt <= '0;
            wait_cnt <= '0;
            data_q   <= '0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (reg_wr_en && reg_sel == SEL_SRC) src_reg <= reg_wdata[ADDR_W-1:0];
            if (reg_wr_en && reg_sel == SEL_DST) dst_reg <= reg_wdata[ADDR_W-1:0];
            if (ctrl_wr) ctrl_q <= reg_wdata;
            if (en_rise) begin
                cur_src <= src_reg;
                cur_dst <= dst_reg;
            end
            case (state)
                ST_IDLE: begin
                    if (start_go) begin
                        rem_cnt  <= count_eff;
                        iter_cnt <= (fld.start_mode == MODE_FIFO && count_eff > REM_W'(FIFO_CHUNK))
                                    ? REM_W'(FIFO_CHUNK) : count_eff;
                        if (fld.dst_step == STEP_UP_RELOAD) cur_dst <= dst_reg;
                        state <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_rd_ready) begin
                        data_q <= mem_rd_data;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_wr_ready) begin
                        cur_src  <= src_nx;
                        cur_dst  <= dst_nx;
                        wait_cnt <= unit_cost;
                        iter_cnt <= iter_cnt - 1'b1;
                        rem_cnt  <= rem_cnt - 1'b1;
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_cnt == COST_W'(1)) begin
                        if (iter_cnt != '0) begin
                            state <= ST_READ;
                        end else if (rem_cnt != '0) begin
                            ctrl_q[CNT_W-1:0] <= rem_cnt[CNT_W-1:0];
                            state <= ST_IDLE;
                        end else begin
                            wait_cnt <= COST_W'(TAIL_CYCLES);
                            state    <= ST_TAIL;
                        end
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (wait_cnt == COST_W'(1)) begin
                        if (!fld.repeat_en) ctrl_q[31] <= 1'b0;
                        irq   <= fld.irq_en;
                        state <= ST_IDLE;
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs derived from the sequencer state
    always_comb begin
        ctrl_word    = ctrl_q;
        mem_wide     = fld.wide;
        mem_rd_valid = (state == ST_READ);
        mem_rd_addr  = cur_src;
        mem_wr_valid = (state == ST_WRITE);
        mem_wr_addr  = cur_dst;
        mem_wr_data  = data_q;
        cpu_halt     = (state != ST_IDLE);
    end
endmodule

// File: rtl/dma_channel_chk.sv
// Protocol checker for the copy channel, attached to every instance by bind.
// Observes only the top-level ports.
module dma_channel_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              halt,
    input logic              irq,
    input logic              en_bit,
    input logic              rpt_bit
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R12
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr)); // R12
    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid)); // R12
    AST_HALT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |-> halt); // R11
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R9
    AST_IRQ_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !rpt_bit |-> !en_bit); // R9
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !halt); // R11
endmodule

bind dma_channel dma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(mem_rd_valid), .rd_ready(mem_rd_ready), .rd_addr(mem_rd_addr),
    .wr_valid(mem_wr_valid), .wr_ready(mem_wr_ready), .wr_addr(mem_wr_addr),
    .halt(cpu_halt), .irq(irq), .en_bit(ctrl_word[31]), .rpt_bit(ctrl_word[25])
);

// File: tb/dma_channel_tb.sv
module dma_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [31:0] KEY = 32'h5A5A_0000;
    localparam int NVEC = 5;
    // {src, dst, ctrl, cost}
    localparam logic [103:0] VEC [NVEC] = '{
        {32'h0200_0000, 32'h0300_0100, 32'hC000_0004, 8'd2},
        {32'h0800_0010, 32'h0200_0000, 32'hC4C0_0003, 8'd14},
        {32'h0A00_0000, 32'h0900_0000, 32'h81A0_0002, 8'd16},
        {32'h0500_0000, 32'h0700_0000, 32'hC660_0005, 8'd3},
        {32'h0400_0000, 32'h0F00_0000, 32'hC400_0001, 8'd2}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  trig_in = '0;
    logic [31:0] ctrl_word, mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
    logic        mem_wide, mem_rd_valid, mem_wr_valid, cpu_halt, irq;
    logic        mem_rd_ready = 1'b1, mem_wr_ready = 1'b1;

    int errors = 0, checks = 0, cyc = 0;
    int nwr = 0, halt_cyc = 0, irq_cnt = 0;
    logic [31:0] wa [256];
    logic [31:0] wd [256];

    assign mem_rd_data = mem_rd_addr ^ KEY;

    dma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .trig_in(trig_in), .ctrl_word(ctrl_word),
        .mem_wide(mem_wide), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready), .cpu_halt(cpu_halt), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
            $finish;
        end
    end

    // Monitor away from the active edge: writes, halt cycles, irq pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr_valid && mem_wr_ready) begin
                if (nwr < 256) begin
                    wa[nwr] = mem_wr_addr;
                    wd[nwr] = mem_wr_data;
                end
                nwr = nwr + 1;
            end
            if (cpu_halt) halt_cyc = halt_cyc + 1;
            if (irq) irq_cnt = irq_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic pulse_trig(input int idx);
        @(negedge clk);
        trig_in[idx] = 1'b1;
        @(negedge clk);
        trig_in[idx] = 1'b0;
    endtask

    task automatic clear_mon();
        nwr = 0; halt_cyc = 0; irq_cnt = 0;
    endtask

    task automatic run_to_idle();
        for (int n = 0; n < 20000 && cpu_halt; n++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] src, input logic [31:0] dst);
        reg_write(2'd2, 32'h0);
        reg_write(2'd0, src);
        reg_write(2'd1, dst);
        clear_mon();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        check(ctrl_word == 32'h0 && !cpu_halt && !irq && !mem_rd_valid && !mem_wr_valid,
              "R13 reset idle", {ctrl_word[30:0], cpu_halt}, 32'h0);

        // Table-driven mode-0 transfers: R2 R3 R4 R9 R10 R11
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] s, d, c, step;
            int cost, n;
            bit addr_ok;
            s = VEC[v][103:72]; d = VEC[v][71:40]; c = VEC[v][39:8]; cost = int'(VEC[v][7:0]);
            n = int'(c[20:0]);
            setup(s, d);
            reg_write(2'd2, c);
            run_to_idle();
            check(nwr == n, "R4 unit count", nwr, n);
            step = c[26] ? 32'd4 : 32'd2;
            addr_ok = 1'b1;
            for (int i = 0; i < n; i++) begin
                if (wa[i] != d || wd[i] != (s ^ KEY)) addr_ok = 1'b0;
                s = (c[24:23] == 2'd1) ? s - step : (c[24:23] == 2'd2) ? s : s + step;
                d = (c[22:21] == 2'd1) ? d - step : (c[22:21] == 2'd2) ? d : d + step;
            end
            check(addr_ok, "R2 R3 R4 address sequence", wa[0], VEC[v][71:40]);
            check(halt_cyc == n * (2 + cost) + 2, "R10 R11 halt cycles", halt_cyc, n * (2 + cost) + 2);
            check(irq_cnt == int'(c[30]), "R9 irq pulse", irq_cnt, c[30]);
            check(ctrl_word[31] == c[25], "R9 enable after completion", ctrl_word[31], c[25]);
        end

        // R6 R1 R2 R8: triggered repeat transfer with destination reload
        setup(32'h0200_0000, 32'h0300_0000);
        reg_write(2'd2, 32'h8A60_0002);
        repeat (4) @(negedge clk);
        reg_write(2'd0, 32'h0200_1000);
        pulse_trig(2);
        repeat (3) @(negedge clk);
        check(halt_cyc == 0 && nwr == 0, "R6 no start without matching trigger", halt_cyc, 0);
        pulse_trig(1);
        repeat (2) @(negedge clk);
        pulse_trig(1);
        run_to_idle();
        check(nwr == 2 && halt_cyc == 10, "R8 busy trigger ignored", halt_cyc, 10);
        check(wd[0] == (32'h0200_0000 ^ KEY), "R1 source loaded on enable edge", wd[0], 32'h0200_0000 ^ KEY);
        clear_mon();
        pulse_trig(1);
        run_to_idle();
        check(wd[0] == (32'h0200_0004 ^ KEY), "R1 source not reloaded", wd[0], 32'h0200_0004 ^ KEY);
        check(wa[0] == 32'h0300_0000, "R2 destination reloaded", wa[0], 32'h0300_0000);

        // R7: FIFO-feed chunking and write-back
        setup(32'h0200_0000, 32'h0400_0000);
        reg_write(2'd2, 32'hF840_0073);
        repeat (2) @(negedge clk);
        check(!cpu_halt, "R6 mode 7 waits for trigger", cpu_halt, 0);
        pulse_trig(7);
        run_to_idle();
        check(nwr == 112 && halt_cyc == 448, "R7 chunk of 112", halt_cyc, 448);
        check(ctrl_word[20:0] == 21'd3 && ctrl_word[31] && irq_cnt == 0,
              "R7 count written back, still armed", ctrl_word, 32'hF840_0003);
        clear_mon();
        pulse_trig(7);
        run_to_idle();
        check(nwr == 3 && halt_cyc == 14 && irq_cnt == 1 && !ctrl_word[31],
              "R7 final chunk completes", halt_cyc, 14);

        // R5: zero count means 2^21 units
        setup(32'h0200_0000, 32'h0400_0000);
        reg_write(2'd2, 32'hB800_0000);
        pulse_trig(7);
        run_to_idle();
        check(ctrl_word[20:0] == 21'h1F_FF90, "R5 zero count remainder", ctrl_word[20:0], 32'h1F_FF90);

        // R12: stalled read keeps request and lengthens transfer
        setup(32'h0200_0000, 32'h0300_0000);
        mem_rd_ready = 1'b0;
        reg_write(2'd2, 32'h8000_0001);
        repeat (3) @(negedge clk);
        check(mem_rd_valid && mem_rd_addr == 32'h0200_0000 && nwr == 0,
              "R12 read held while stalled", mem_rd_addr, 32'h0200_0000);
        mem_rd_ready = 1'b1;
        run_to_idle();
        check(nwr == 1 && halt_cyc == 9, "R12 stall adds cycles", halt_cyc, 9);

        // R13: reset mid-transfer returns to idle
        setup(32'h0200_0000, 32'h0300_0000);
        reg_write(2'd2, 32'h8000_0010);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_halt && ctrl_word == 32'h0, "R13 reset during transfer", ctrl_word, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule